// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division on two operands, signed or unsigned, one bit per clock cycle, while the rest of the pipeline keeps running. Results land in a pair of result registers named HI and LO. A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI.

The pipeline reads either register through a select. While an operation is still iterating, any read raises a stall so that stale data is never consumed. Instructions that neither read HI nor LO never wait on the unit. A separate write port loads HI or LO directly from a general register, which is how state is put back after an exception. Such a write also cancels any operation still in flight.

Top module: `muldiv_hilo`

## Requirements
- R1: With cmd_div=0 the unit multiplies cmd_a by cmd_b, as two's complement values when cmd_signed=1 and as unsigned values when cmd_signed=0. HI receives bits 63..32 of the 64-bit product and LO receives bits 31..0.
- R2: With cmd_div=1 the unit divides cmd_a by cmd_b, putting the quotient in LO and the remainder in HI. Signed division truncates toward zero and the remainder takes the sign of the dividend. The signed case 0x80000000 / 0xFFFFFFFF gives LO=0x80000000 and HI=0.
- R3: A divide by zero, signed or unsigned, raises no error. It completes in the normal time with HI equal to the dividend and LO equal to 0xFFFFFFFF.
- R4: A command is accepted on a clock edge where cmd_valid=1, busy=0 and wr_en=0. busy is high from the next cycle for exactly 32 cycles. HI and LO hold the new result in the first cycle where busy is low again.
- R5: rd_data shows HI when rd_sel=1 and LO when rd_sel=0. rd_stall is 1 exactly when rd_en=1 while busy=1.
- R6: cmd_valid while busy=1 is ignored. The operation in flight completes with its own operands, and the ignored command starts nothing afterwards.
- R7: wr_en=1 loads wr_data into HI when wr_sel=1 and into LO when wr_sel=0, visible the next cycle. The other register is unchanged.
- R8: wr_en=1 while busy=1 aborts the operation: busy is low the next cycle, the written register holds wr_data, and the other register keeps its value from before the aborted command, also after 32 more cycles.
- R9: When cmd_valid=1 and wr_en=1 arrive together while idle, the write takes effect and the command is not accepted: busy stays low.
- R10: After reset HI=0, LO=0 and busy=0. Without a write or a completing operation, HI and LO keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_div | input | 1 | 1 = divide, 0 = multiply |
| cmd_signed | input | 1 | 1 = operands are two's complement |
| cmd_a | input | 32 | Multiplicand or dividend |
| cmd_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in flight |
| rd_en | input | 1 | Pipeline is reading HI or LO |
| rd_sel | input | 1 | 1 = read HI, 0 = read LO |
| rd_data | output | 32 | Selected result register |
| rd_stall | output | 1 | Read must wait |
| wr_en | input | 1 | Direct load of HI or LO |
| wr_sel | input | 1 | 1 = load HI, 0 = load LO |
| wr_data | input | 32 | Value to load |

## Verification
Two functions can collide in one cycle. A direct write can meet a running operation, and it can meet a new command while the unit is idle. The bench provokes the first by asserting wr_en a few cycles into a multiply. It then checks that busy drops the next cycle, that the written register holds the new value, and that the other register keeps its old value after the iteration window has passed. The bench provokes the second by raising cmd_valid and wr_en on the same edge. It checks that busy stays low and that only the write landed.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic         cmd_div,
  input  logic         cmd_signed,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_stall,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hi_q, lo_q;
  logic [W-1:0]  src_q, opd_q, lw_q;
  logic [W:0]    up_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, div_q, negq_q, negr_q, dz_q;

  wire start = cmd_valid && !busy_q && !wr_en;
  wire last  = busy_q && (cnt_q == LAST);

  wire         a_neg = cmd_signed && cmd_a[W-1];
  wire         b_neg = cmd_signed && cmd_b[W-1];
  wire [W-1:0] a_mag = a_neg ? -cmd_a : cmd_a;
  wire [W-1:0] b_mag = b_neg ? -cmd_b : cmd_b;

  wire [W:0]   m_sum = {1'b0, up_q[W-1:0]} + (lw_q[0] ? {1'b0, opd_q} : '0);
  wire [W:0]   d_sh  = {up_q[W-1:0], lw_q[W-1]};
  wire [W+1:0] d_try = {1'b0, d_sh} - {2'b00, opd_q};
  wire         d_ok  = !d_try[W+1];

  logic [W:0]   nxt_up;
  logic [W-1:0] nxt_lw;
  always_comb begin
    if (div_q) begin
      nxt_up = d_ok ? d_try[W:0] : d_sh;
      nxt_lw = {lw_q[W-2:0], d_ok};
    end else begin
      nxt_up = {1'b0, m_sum[W:1]};
      nxt_lw = {m_sum[0], lw_q[W-1:1]};
    end
  end

  wire [2*W-1:0] prod   = {nxt_up[W-1:0], nxt_lw};
  wire [2*W-1:0] prod_s = negq_q ? -prod : prod;
  wire [W-1:0]   quo    = negq_q ? -nxt_lw : nxt_lw;
  wire [W-1:0]   rem    = negr_q ? -nxt_up[W-1:0] : nxt_up[W-1:0];
  wire [W-1:0]   res_hi = !div_q ? prod_s[2*W-1:W] : (dz_q ? src_q : rem);
  wire [W-1:0]   res_lo = !div_q ? prod_s[W-1:0]   : (dz_q ? '1 : quo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
      src_q  <= '0;
      opd_q  <= '0;
      lw_q   <= '0;
      up_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      div_q  <= cmd_div;
      negq_q <= a_neg ^ b_neg;
      negr_q <= a_neg;
      dz_q   <= cmd_div && (cmd_b == '0);
      src_q  <= cmd_a;
      opd_q  <= cmd_div ? b_mag : a_mag;
      lw_q   <= cmd_div ? a_mag : b_mag;
      up_q   <= '0;
    end else if (busy_q) begin
      busy_q <= !(wr_en || last);
      cnt_q  <= cnt_q + 1'b1;
      up_q   <= nxt_up;
      lw_q   <= nxt_lw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) hi_q <= wr_data;
      else        lo_q <= wr_data;
    end else if (last) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end
  end

  assign busy     = busy_q;
  assign rd_data  = rd_sel ? hi_q : lo_q;
  assign rd_stall = rd_en && busy_q;
endmodule

module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         busy,
  input logic         rd_en,
  input logic         rd_stall,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  // R4
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && !wr_en) |=> busy);
  // R5
  stall_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> (busy && rd_en));
  // R7
  write_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (hi_q == $past(wr_data)) && $stable(lo_q));
  // R7
  write_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (lo_q == $past(wr_data)) && $stable(hi_q));
  // R8
  abort_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> !busy);
  // R9
  write_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en) |=> !busy);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(hi_q) && $stable(lo_q));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_muldiv_hilo_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
  .rd_en(rd_en), .rd_stall(rd_stall), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/muldiv_hilo_bench.sv
module muldiv_hilo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_div = 1'b0, cmd_signed = 1'b0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        busy;
  logic        rd_en = 1'b0, rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        rd_stall;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  muldiv_hilo u_muldiv_hilo (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_div(cmd_div),
    .cmd_signed(cmd_signed), .cmd_a(cmd_a), .cmd_b(cmd_b), .busy(busy),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_stall(rd_stall),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  function automatic logic [63:0] expect_res(bit dv, bit sg, logic [31:0] a, logic [31:0] b);
    longint sa, sb, p, q, r;
    sa = sg ? longint'($signed(a)) : longint'({32'b0, a});
    sb = sg ? longint'($signed(b)) : longint'({32'b0, b});
    if (!dv) begin
      p = sa * sb;
      return p;
    end
    if (b == 32'd0) return {a, 32'hFFFF_FFFF};
    q = sa / sb;
    r = sa % sb;
    return {r[31:0], q[31:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_pair(output logic [31:0] h, output logic [31:0] l);
    rd_en = 1'b1; rd_sel = 1'b1; #1 h = rd_data;
    rd_sel = 1'b0; #1 l = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic run_op(string req, bit dv, bit sg, logic [31:0] a, logic [31:0] b, bit poke);
    logic [63:0] e;
    logic [31:0] h, l;
    int n;
    e = expect_res(dv, sg, a, b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_div = dv; cmd_signed = sg; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R4 busy after accept", {31'b0, busy}, 32'd1);
    n = 0;
    while (busy) begin
      n++;
      if (n == 3) begin
        rd_en = 1'b1; #1;
        chk("R5 stall while busy", {31'b0, rd_stall}, 32'd1);
        rd_en = 1'b0;
        if (poke) begin
          // R6: a second command while busy must be ignored
          cmd_valid = 1'b1; cmd_div = ~dv; cmd_a = ~a; cmd_b = b + 32'd7;
        end
      end
      if (n == 4) cmd_valid = 1'b0;
      if (n > 100) break;
      @(negedge clk);
    end
    chk("R4 busy length", n, 32'd32);
    rd_en = 1'b1; #1;
    chk("R5 no stall when idle", {31'b0, rd_stall}, 32'd0);
    read_pair(h, l);
    chk({req, " HI"}, h, e[63:32]);
    chk({req, " LO"}, l, e[31:0]);
    if (poke) begin
      repeat (2) @(negedge clk);
      chk("R6 no late start", {31'b0, busy}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] h, l, s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R10 reset state
    read_pair(h, l);
    chk("R10 reset HI", h, 32'd0);
    chk("R10 reset LO", l, 32'd0);
    chk("R10 reset busy", {31'b0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 mul unsigned max", 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op("R1 mul signed neg*pos", 1'b0, 1'b1, 32'hFFFF_FFF9, 32'd12345, 1'b0);
    run_op("R1 mul signed min*min", 1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0);
    run_op("R2 div signed neg/pos", 1'b1, 1'b1, 32'hFFFF_FF9D, 32'd7, 1'b0);
    run_op("R2 div signed pos/neg", 1'b1, 1'b1, 32'd100, 32'hFFFF_FFF9, 1'b0);
    run_op("R2 div signed overflow", 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    run_op("R2 div unsigned big", 1'b1, 1'b0, 32'hFFFF_FFFE, 32'h8000_0001, 1'b0);
    run_op("R3 div zero unsigned", 1'b1, 1'b0, 32'h1234_5678, 32'd0, 1'b0);
    run_op("R3 div zero signed", 1'b1, 1'b1, 32'h8765_4321, 32'd0, 1'b0);
    run_op("R6 ignored command", 1'b0, 1'b0, 32'd1000, 32'd3000, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 5 == 0) rb = rb >> 20;
      run_op(((i % 2) != 0) ? "R2 random div" : "R1 random mul",
             (i % 2) != 0, ((i / 2) % 2) != 0, ra, rb, 1'b0);
    end

    // R7 direct write of HI, LO untouched
    read_pair(h, l);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'hCAFE_0001;
    @(negedge clk);
    wr_en = 1'b0;
    begin
      logic [31:0] h2, l2;
      read_pair(h2, l2);
      chk("R7 HI written", h2, 32'hCAFE_0001);
      chk("R7 LO kept", l2, l);
    end
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0BAD_F00D;
    @(negedge clk);
    wr_en = 1'b0;
    read_pair(h, l);
    chk("R7 LO written", l, 32'h0BAD_F00D);
    chk("R7 HI kept", h, 32'hCAFE_0001);

    // R8 write during busy aborts
    @(negedge clk);
    cmd_valid = 1'b1; cmd_div = 1'b0; cmd_signed = 1'b0; cmd_a = 32'd77; cmd_b = 32'd99;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h5555_AAAA;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 busy dropped", {31'b0, busy}, 32'd0);
    repeat (40) @(negedge clk);
    read_pair(h, l);
    chk("R8 LO written", l, 32'h5555_AAAA);
    chk("R8 HI kept", h, 32'hCAFE_0001);

    // R9 write and command together while idle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_div = 1'b1; cmd_a = 32'd50; cmd_b = 32'd5;
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h1111_2222;
    @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
    chk("R9 not started", {31'b0, busy}, 32'd0);
    repeat (40) @(negedge clk);
    read_pair(h, l);
    chk("R9 HI written", h, 32'h1111_2222);
    chk("R9 LO kept", l, 32'h5555_AAAA);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule